// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor that reads and writes single words and a slow main memory that is accessed one word per handshake. Each word address is split into a tag, a frame index and a word offset. The index selects exactly one frame. A single comparison of that frame's stored tag, gated by its valid flag, decides whether the access hits.

Write hits stay local: they update only the cached word and mark the frame dirty. A read miss first copies a dirty victim back to memory as a whole block. It then refills the frame. The refill starts at the requested word and wraps around the block, and that word is handed to the processor as soon as it arrives, while the rest of the block is still loading. A write miss does not allocate a frame: it sends the single word straight to memory.

The processor may issue a request only while `cpu_idle` is high. It then waits for the one-cycle `cpu_ready` pulse. `cpu_idle` returns high only after any refill has finished.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every frame is invalid, `cpu_idle` is 1, and `mem_req` and `cpu_ready` are 0. The first read of any address therefore misses.
- R2: With the default widths the 7-bit word address is {tag[6:5], index[4:3], offset[2:0]}. Memory block b (address bits [6:3]) can live only in frame b mod 4. An access to one index never disturbs the frame of another index.
- R3: A read hit returns the cached word with one `cpu_ready` pulse and makes no memory access.
- R4: A write hit updates only the cached word and makes no memory access. A later read of that address returns the new value.
- R5: A read miss on an invalid or clean frame makes exactly 8 memory reads, all within the requested block, and no memory writes.
- R6: A read miss on a dirty frame first makes exactly 8 memory writes of the victim block, at offsets 0 through 7 in ascending order and carrying the cached data. Only then does the first refill read begin.
- R7: During a refill the first memory read is at the requested offset and later reads wrap modulo 8. `cpu_ready` pulses exactly once, for one cycle, with the requested word, while `cpu_idle` is still 0.
- R8: A write miss makes exactly one memory write of the word at its address and allocates no frame. A later read of that address misses and returns the written value.
- R9: After a refill the frame holds the new tag, is valid and is clean, so a later eviction of it writes nothing back.
- R10: `cpu_idle` falls in the cycle after a request is accepted and stays low until the operation is complete. `cpu_req` is ignored while `cpu_idle` is low.
- R11: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, sampled while `cpu_idle` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_idle | output | 1 | Controller can accept a request |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the current transfer (one-cycle pulse) |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The hardest case to reach is a dirty eviction whose refill starts mid-block. Producing it takes four steps from the ports: a read to allocate a frame, a write hit to dirty it, another block's read at the same index, and a nonzero (or last) offset in that read.

The stimulus runs this chain twice, once at offset 2 and once at offset 7. A bench memory model logs every transfer, so the order of the write-back and the refill is checked word by word.

A request is also injected after the forwarded word has arrived but while the refill is still running, to show that it is ignored.

// File: rtl/cache_pkg.sv
package cache_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_EVICT,
      ST_REFILL,
      ST_WRMISS
   } ctrl_state_t;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
   parameter int TAG_W = 2,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic             lk_valid,
   output logic             lk_dirty,
   output logic [TAG_W-1:0] lk_stored_tag,
   input  logic             mark_dirty,
   input  logic             fill_done,
   input  logic [TAG_W-1:0] fill_tag
);
   localparam int FRAMES = 1 << IDX_W;

   logic             v_arr [FRAMES];
   logic             d_arr [FRAMES];
   logic [TAG_W-1:0] t_arr [FRAMES];

   for (genvar g = 0; g < FRAMES; g++) begin : g_frame
      logic             v_q, d_q;
      logic [TAG_W-1:0] t_q;
      logic             sel;
      assign sel = (lk_idx == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            t_q <= '0;
         end else if (fill_done && sel) begin
            v_q <= 1'b1;
            d_q <= 1'b0;
            t_q <= fill_tag;
         end else if (mark_dirty && sel) begin
            d_q <= 1'b1;
         end
      end
      assign v_arr[g] = v_q;
      assign d_arr[g] = d_q;
      assign t_arr[g] = t_q;
   end

   assign lk_valid      = v_arr[lk_idx];
   assign lk_dirty      = d_arr[lk_idx];
   assign lk_stored_tag = t_arr[lk_idx];
   assign lk_hit        = lk_valid && (lk_stored_tag == lk_tag);
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2,
   parameter int OFF_W  = 3
) (
   input  logic                   clk,
   input  logic                   wr_en,
   input  logic [IDX_W+OFF_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [IDX_W+OFF_W-1:0] rd_addr,
   output logic [DATA_W-1:0]      rd_data
);
   localparam int DEPTH = 1 << (IDX_W + OFF_W);

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) words[wr_addr] <= wr_data;
   end

   assign rd_data = words[rd_addr];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
   import cache_pkg::*;
#(
   parameter int  ADDR_W     = 7,
   parameter int  DATA_W     = 32,
   parameter int  IDX_W      = 2,
   parameter int  OFF_W      = 3,
   parameter bit  CRIT_FIRST = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cpu_req,
   input  logic                   cpu_we,
   input  logic [ADDR_W-1:0]      cpu_addr,
   input  logic [DATA_W-1:0]      cpu_wdata,
   output logic                   cpu_idle,
   output logic                   cpu_ready,
   output logic [DATA_W-1:0]      cpu_rdata,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_wdata,
   input  logic                   mem_ack,
   input  logic [DATA_W-1:0]      mem_rdata,
   output logic [IDX_W-1:0]       ts_idx,
   output logic [ADDR_W-IDX_W-OFF_W-1:0] ts_tag,
   input  logic                   ts_hit,
   input  logic                   ts_valid,
   input  logic                   ts_dirty,
   input  logic [ADDR_W-IDX_W-OFF_W-1:0] ts_stored_tag,
   output logic                   ts_mark_dirty,
   output logic                   ts_fill_done,
   output logic                   ds_wr_en,
   output logic [IDX_W+OFF_W-1:0] ds_wr_addr,
   output logic [DATA_W-1:0]      ds_wr_data,
   output logic [IDX_W+OFF_W-1:0] ds_rd_addr,
   input  logic [DATA_W-1:0]      ds_rd_data
);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
   localparam logic [OFF_W-1:0] LAST = '1;

   ctrl_state_t       state_q;
   logic              we_q;
   logic [TAG_W-1:0]  tag_q, vtag_q;
   logic [IDX_W-1:0]  idx_q;
   logic [OFF_W-1:0]  off_q, cnt_q, fill_off;
   logic [DATA_W-1:0] wdata_q;
   logic              rdy_q;
   logic [DATA_W-1:0] rdata_q;

   if (CRIT_FIRST) begin : g_wrap_fill
      assign fill_off = off_q + cnt_q;
   end else begin : g_linear_fill
      assign fill_off = cnt_q;
   end

   assign ts_idx     = idx_q;
   assign ts_tag     = tag_q;
   assign ds_rd_addr = (state_q == ST_EVICT) ? {idx_q, cnt_q} : {idx_q, off_q};

   assign cpu_idle  = (state_q == ST_IDLE);
   assign cpu_ready = rdy_q;
   assign cpu_rdata = rdata_q;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = {tag_q, idx_q, off_q};
      mem_wdata = wdata_q;
      unique case (state_q)
         ST_EVICT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {vtag_q, idx_q, cnt_q};
            mem_wdata = ds_rd_data;
         end
         ST_REFILL: begin
            mem_req  = 1'b1;
            mem_addr = {tag_q, idx_q, fill_off};
         end
         ST_WRMISS: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      ds_wr_en      = 1'b0;
      ds_wr_addr    = {idx_q, off_q};
      ds_wr_data    = wdata_q;
      ts_mark_dirty = 1'b0;
      ts_fill_done  = 1'b0;
      if (state_q == ST_LOOKUP && ts_hit && we_q) begin
         ds_wr_en      = 1'b1;
         ts_mark_dirty = 1'b1;
      end else if (state_q == ST_REFILL && mem_ack) begin
         ds_wr_en     = 1'b1;
         ds_wr_addr   = {idx_q, fill_off};
         ds_wr_data   = mem_rdata;
         ts_fill_done = (cnt_q == LAST);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         tag_q   <= '0;
         vtag_q  <= '0;
         idx_q   <= '0;
         off_q   <= '0;
         cnt_q   <= '0;
         wdata_q <= '0;
         rdy_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         rdy_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cpu_req) begin
                  we_q    <= cpu_we;
                  {tag_q, idx_q, off_q} <= cpu_addr;
                  wdata_q <= cpu_wdata;
                  state_q <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               cnt_q <= '0;
               if (ts_hit) begin
                  rdy_q   <= 1'b1;
                  if (!we_q) rdata_q <= ds_rd_data;
                  state_q <= ST_IDLE;
               end else if (we_q) begin
                  state_q <= ST_WRMISS;
               end else if (ts_valid && ts_dirty) begin
                  vtag_q  <= ts_stored_tag;
                  state_q <= ST_EVICT;
               end else begin
                  state_q <= ST_REFILL;
               end
            end
            ST_EVICT: begin
               if (mem_ack) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == LAST) state_q <= ST_REFILL;
               end
            end
            ST_REFILL: begin
               if (mem_ack) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (fill_off == off_q) begin
                     rdy_q   <= 1'b1;
                     rdata_q <= mem_rdata;
                  end
                  if (cnt_q == LAST) state_q <= ST_IDLE;
               end
            end
            ST_WRMISS: begin
               if (mem_ack) begin
                  rdy_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 2,
   parameter int OFF_W      = 3,
   parameter bit CRIT_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_idle,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   if (TAG_W < 1) begin : g_bad_split
      $error("ADDR_W must exceed IDX_W + OFF_W");
   end
   if (OFF_W < 1 || IDX_W < 1) begin : g_bad_geom
      $error("IDX_W and OFF_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic [IDX_W-1:0]       ts_idx;
   logic [TAG_W-1:0]       ts_tag, ts_stored_tag;
   logic                   ts_hit, ts_valid, ts_dirty, ts_mark_dirty, ts_fill_done;
   logic                   ds_wr_en;
   logic [IDX_W+OFF_W-1:0] ds_wr_addr, ds_rd_addr;
   logic [DATA_W-1:0]      ds_wr_data, ds_rd_data;

   cache_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) tags_i (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(ts_idx), .lk_tag(ts_tag),
      .lk_hit(ts_hit), .lk_valid(ts_valid), .lk_dirty(ts_dirty),
      .lk_stored_tag(ts_stored_tag),
      .mark_dirty(ts_mark_dirty), .fill_done(ts_fill_done), .fill_tag(ts_tag)
   );

   cache_data_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) data_i (
      .clk(clk),
      .wr_en(ds_wr_en), .wr_addr(ds_wr_addr), .wr_data(ds_wr_data),
      .rd_addr(ds_rd_addr), .rd_data(ds_rd_data)
   );

   cache_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
      .CRIT_FIRST(CRIT_FIRST)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_idle(cpu_idle), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .ts_idx(ts_idx), .ts_tag(ts_tag), .ts_hit(ts_hit), .ts_valid(ts_valid),
      .ts_dirty(ts_dirty), .ts_stored_tag(ts_stored_tag),
      .ts_mark_dirty(ts_mark_dirty), .ts_fill_done(ts_fill_done),
      .ds_wr_en(ds_wr_en), .ds_wr_addr(ds_wr_addr), .ds_wr_data(ds_wr_data),
      .ds_rd_addr(ds_rd_addr), .ds_rd_data(ds_rd_data)
   );
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_idle,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack
);
   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);                                           // R7
   AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_idle |-> !mem_req);                                              // R3
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_idle && cpu_req) |=> !cpu_idle);                                // R10
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));                  // R11
   AST_FILL_ONE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && $past(mem_req && !mem_we))
         |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]))); // R5
   AST_EVICT_ONE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && $past(mem_req && mem_we))
         |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]))); // R6
endmodule

bind dm_wb_cache cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_idle(cpu_idle),
   .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/dm_wb_cache_tb_top.sv
module dm_wb_cache_tb_top;
   localparam int AW  = 7;
   localparam int DW  = 32;
   localparam int LAT = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_idle, cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   dm_wb_cache dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_idle(cpu_idle), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int checks = 0, errors = 0;
   logic [DW-1:0] bmem [1<<AW];
   logic [DW-1:0] ref_mem [1<<AW];
   logic [7:0]    mlog [$];
   logic [DW-1:0] exp_q [$];
   int            wait_cnt = 0;
   int            ready_cnt = 0;
   logic          idle_at_ready = 1'b0;
   logic          cur_we = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory model: one word per handshake, fixed latency
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack  <= 1'b0;
         wait_cnt <= 0;
      end else if (mem_ack) begin
         mem_ack  <= 1'b0;
         wait_cnt <= 0;
      end else if (mem_req) begin
         if (wait_cnt == LAT) begin
            mem_ack  <= 1'b1;
            wait_cnt <= 0;
            if (mem_we) bmem[mem_addr] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr];
            mlog.push_back({mem_we, mem_addr});
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && cpu_ready) begin
         ready_cnt++;
         idle_at_ready = cpu_idle;
         if (!cur_we) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected read data", cpu_rdata, '0);
            else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               chk(cpu_rdata == e, "R3/R7 read data", cpu_rdata, e);
            end
         end
      end
   end

   task automatic op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
      while (!cpu_idle) @(negedge clk);
      mlog.delete();
      ready_cnt = 0;
      cur_we = we;
      if (we) ref_mem[a] = d;
      else exp_q.push_back(ref_mem[a]);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0;
      @(negedge clk);
      while (!cpu_idle) begin
         if (poke && cpu_ready) begin
            cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = '0; cpu_wdata = 32'hBAD0BAD0;
            @(negedge clk);
            cpu_req = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
      @(negedge clk);
      chk(ready_cnt == 1, "R7 one ready pulse per operation", ready_cnt, 1);
   endtask

   // check 8 log entries from pos: direction we, block of base, offsets start, start+1, ...
   task automatic chk_block(input bit we, input logic [AW-1:0] base, input int start, input int pos, input string req);
      bit ok = (mlog.size() >= pos + 8);
      logic [7:0] act = 8'hFF, exp = 8'hFF;
      for (int i = 0; i < 8 && ok; i++) begin
         exp = {we, base[6:3], 3'((start + i) % 8)};
         act = mlog[pos + i];
         if (act != exp) ok = 1'b0;
      end
      chk(ok, req, act, exp);
   endtask

   bit done = 1'b0;
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1<<AW); i++) begin
         bmem[i]    = 32'hA500_0000 ^ (i * 32'h0101_0101);
         ref_mem[i] = bmem[i];
      end
      repeat (4) @(negedge clk);
      chk(cpu_idle == 1'b1, "R1 idle after reset", cpu_idle, 1);
      chk(mem_req == 1'b0, "R1 no memory request in reset", mem_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_idle == 1'b1 && mem_req == 1'b0 && cpu_ready == 1'b0, "R1 quiet after reset",
          {cpu_idle, mem_req, cpu_ready}, 3'b100);

      // first read misses, refill starts at offset 3 and wraps
      op(1'b0, 7'h2B, '0, 1'b0);
      chk(mlog.size() == 8, "R1/R5 first read refills 8 words", mlog.size(), 8);
      chk_block(1'b0, 7'h28, 3, 0, "R7 critical-word-first wrap order");
      chk(idle_at_ready == 1'b0, "R7 word forwarded before refill ends", idle_at_ready, 0);

      op(1'b0, 7'h28, '0, 1'b0);
      chk(mlog.size() == 0, "R3 read hit no memory access", mlog.size(), 0);

      op(1'b1, 7'h2D, 32'hDEAD_0001, 1'b0);
      chk(mlog.size() == 0, "R4 write hit no memory access", mlog.size(), 0);
      op(1'b0, 7'h2D, '0, 1'b0);
      chk(mlog.size() == 0, "R4 read after write hit", mlog.size(), 0);

      // dirty eviction, same index 1, different tag
      op(1'b0, 7'h4A, '0, 1'b0);
      chk(mlog.size() == 16, "R6 dirty eviction 8 writes plus 8 reads", mlog.size(), 16);
      chk_block(1'b1, 7'h28, 0, 0, "R6 write-back ascending before refill");
      chk_block(1'b0, 7'h48, 2, 8, "R2/R7 refill of frame i mod 4");
      chk(bmem[7'h2D] == 32'hDEAD_0001, "R6 dirty data written back", bmem[7'h2D], 32'hDEAD_0001);

      // refilled frame is clean; a request during the refill is ignored
      op(1'b0, 7'h28, '0, 1'b1);
      chk(mlog.size() == 8, "R9/R10 clean eviction writes nothing, poke ignored", mlog.size(), 8);
      chk_block(1'b0, 7'h28, 0, 0, "R9 clean refill reads only");

      // write miss: no allocation
      op(1'b1, 7'h70, 32'hBEEF_0002, 1'b0);
      chk(mlog.size() == 1 && mlog[0] == {1'b1, 7'h70}, "R8 write miss single memory write",
          mlog.size(), 1);
      op(1'b0, 7'h10, '0, 1'b0);
      chk(mlog.size() == 8, "R8 write miss left frame unallocated", mlog.size(), 8);
      chk_block(1'b0, 7'h10, 0, 0, "R5 refill from offset 0");
      op(1'b0, 7'h70, '0, 1'b0);
      chk(mlog.size() == 8, "R8 read of write-miss address misses", mlog.size(), 8);

      // other index does not disturb frame 2
      op(1'b0, 7'h18, '0, 1'b0);
      op(1'b0, 7'h74, '0, 1'b0);
      chk(mlog.size() == 0, "R2 other index leaves frame intact", mlog.size(), 0);

      // dirty eviction with refill at the last offset
      op(1'b1, 7'h77, 32'h1234_5678, 1'b0);
      op(1'b0, 7'h57, '0, 1'b0);
      chk(mlog.size() == 16, "R6 second dirty eviction", mlog.size(), 16);
      chk_block(1'b1, 7'h70, 0, 0, "R6 write-back of block 0x70");
      chk_block(1'b0, 7'h50, 7, 8, "R7 wrap from offset 7");
      chk(bmem[7'h77] == 32'h1234_5678, "R6 written-back word", bmem[7'h77], 32'h1234_5678);

      op(1'b0, 7'h2D, '0, 1'b0);
      chk(mlog.size() == 0, "R3 hit on block reloaded after write-back", mlog.size(), 0);
      chk(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule